// File: doc/BRIEF.md
# Dual-Channel Audio Level Meter

This block tracks the power profile of two audio channels after the processing chain and before modulation. Each channel receives a signed 24-bit sample with its own valid strobe. A detector turns the sample into a non-negative magnitude, either its absolute value or a scaled square for an RMS-style reading. A one-pole exponential averager then smooths the magnitude. A programmable signed coefficient sets the weight given to the previous level.

Each channel keeps its smoothed level in a 32-bit unsigned register. Both registers are read through a small combinational read port. The detector mode and the averaging coefficient are shared by the two channels. Each channel has its own detector, averager and level register.

Top module: `audio_level_meter`

## Requirements
- R1: While reset is asserted, and after it is released, both level registers read zero until a valid sample arrives.
- R2: With `det_mode`=0 the detector output is |x|. The most negative sample, 0x800000, yields 8388608.
- R3: With `det_mode`=1 the detector output is floor(x·x / 2^15).
- R4: On each valid sample the level becomes the round-half-up value of ((2^23 − a)·d + a·L) / 2^23, computed at full precision. Here a is the coefficient as a signed integer, d is the detector output and L is the previous level.
- R5: A channel whose valid strobe is low keeps its level unchanged, whatever its sample input does.
- R6: The two channels update independently. A valid sample on one channel leaves the other channel's level unchanged.
- R7: The level saturates. A result below zero is stored as 0, and a result above 2^32−1 is stored as 0xFFFFFFFF.
- R8: `coef` is 26-bit two's complement with 23 fractional bits. Bit 25 set means a negative weight: 0x3C00000 is −0.5 and 0x3800000 is −1.0.
- R9: A read of address 0x6B returns the channel 0 level, and a read of 0x6C returns the channel 1 level. Any other address returns 0.
- R10: One `det_mode` value applies to both channels in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously inside the block |
| det_mode | input | 1 | Detector select: 0 absolute value, 1 square |
| coef | input | 26 | Averaging weight a, signed, 23 fractional bits |
| ch0_valid | input | 1 | Channel 0 sample strobe |
| ch0_sample | input | 24 | Channel 0 signed sample |
| ch1_valid | input | 1 | Channel 1 sample strobe |
| ch1_sample | input | 24 | Channel 1 signed sample |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Read data for `rd_addr`, same cycle |

## Verification
The saturation limits are the hardest states to reach from the ports. A single sample never exceeds 2^31 in square mode, so the top limit cannot be reached directly. The stimulus first loads a near full-scale level with a zero weight. It then applies a weight of 1.5 with zero-valued samples, so the level grows by half each step until it clamps. For the lower limit it applies a weight of −1.0 with zero samples, which drives the ideal result negative.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int SAMPLE_W  = 24;
  localparam int COEF_W    = 26;
  localparam int COEF_FRAC = 23;
  localparam int LEVEL_W   = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_CH    = 2;

  typedef enum logic {
    DET_ABS = 1'b0,
    DET_SQR = 1'b1
  } det_mode_e;
endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/alm_detector.sv
module alm_detector
  import alm_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int LW = LEVEL_W
) (
  input  logic                 mode,
  input  logic signed [SW-1:0] sample,
  output logic        [LW-1:0] mag
);
  localparam int SQ_W     = 2 * SW;
  localparam int SQ_SHIFT = SQ_W - 1 - LW;
  localparam logic [SW-1:0] ONE = SW'(1);

  logic [SW-1:0]          abs_v;
  logic signed [SQ_W-1:0] sq_v;

  always_comb begin
    if (sample[SW-1]) abs_v = ~sample + ONE;
    else              abs_v = sample;
  end

  always_comb begin
    sq_v = SQ_W'(sample) * SQ_W'(sample);
  end

  always_comb begin
    if (det_mode_e'(mode) == DET_SQR) mag = LW'(sq_v >> SQ_SHIFT);
    else                              mag = LW'(abs_v);
  end
endmodule

// File: rtl/alm_round_sat.sv
module alm_round_sat #(
  parameter int SUM_W = 61,
  parameter int FRAC  = 23,
  parameter int OUT_W = 32
) (
  input  logic signed [SUM_W-1:0] acc,
  output logic        [OUT_W-1:0] q
);
  localparam logic signed [SUM_W-1:0] RND =
    {{(SUM_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [SUM_W-1:0] rnd_sum;
  logic signed [SUM_W-1:0] shifted;

  always_comb begin
    rnd_sum = acc + RND;
    shifted = rnd_sum >>> FRAC;
  end

  always_comb begin
    if (shifted[SUM_W-1])              q = '0;
    else if (|shifted[SUM_W-2:OUT_W])  q = '1;
    else                               q = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/alm_averager.sv
module alm_averager
  import alm_pkg::*;
#(
  parameter int LW = LEVEL_W,
  parameter int CW = COEF_W,
  parameter int CF = COEF_FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] det,
  input  logic [CW-1:0] coef,
  output logic [LW-1:0] level
);
  localparam int DS_W   = LW + 1;
  localparam int CS_W   = CW + 1;
  localparam int PROD_W = DS_W + CS_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [CS_W-1:0] UNITY =
    {{(CW-CF){1'b0}}, 1'b1, {CF{1'b0}}};

  logic signed [CS_W-1:0]   coef_s;
  logic signed [CS_W-1:0]   keep_w;
  logic signed [DS_W-1:0]   det_s;
  logic signed [DS_W-1:0]   prev_s;
  logic signed [PROD_W-1:0] p_new;
  logic signed [PROD_W-1:0] p_old;
  logic signed [SUM_W-1:0]  acc;
  logic [LW-1:0]            sat_v;
  logic [LW-1:0]            level_d;
  logic [LW-1:0]            level_q;

  always_comb begin
    coef_s = $signed({coef[CW-1], coef});
    keep_w = UNITY - coef_s;
    det_s  = $signed({1'b0, det});
    prev_s = $signed({1'b0, level_q});
    p_new  = PROD_W'(det_s) * PROD_W'(keep_w);
    p_old  = PROD_W'(prev_s) * PROD_W'(coef_s);
    acc    = SUM_W'(p_new) + SUM_W'(p_old);
  end

  alm_round_sat #(
    .SUM_W (SUM_W),
    .FRAC  (CF),
    .OUT_W (LW)
  ) i_round_sat (
    .acc (acc),
    .q   (sat_v)
  );

  always_comb begin
    level_d = level_q;
    if (en) level_d = sat_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/audio_level_meter.sv
module audio_level_meter
  import alm_pkg::*;
#(
  parameter int               SW        = SAMPLE_W,
  parameter int               CW        = COEF_W,
  parameter int               CF        = COEF_FRAC,
  parameter int               LW        = LEVEL_W,
  parameter int               AW        = ADDR_W,
  parameter logic [ADDR_W-1:0] LVL0_ADDR = 8'h6B,
  parameter logic [ADDR_W-1:0] LVL1_ADDR = 8'h6C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 det_mode,
  input  logic [CW-1:0]        coef,
  input  logic                 ch0_valid,
  input  logic signed [SW-1:0] ch0_sample,
  input  logic                 ch1_valid,
  input  logic signed [SW-1:0] ch1_sample,
  input  logic [AW-1:0]        rd_addr,
  output logic [LW-1:0]        rd_data
);
  logic                 rst_s_n;
  logic [NUM_CH-1:0]    vld;
  logic signed [SW-1:0] smp [NUM_CH];
  logic [LW-1:0]        mag [NUM_CH];
  logic [LW-1:0]        lvl [NUM_CH];

  alm_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  always_comb begin
    vld    = {ch1_valid, ch0_valid};
    smp[0] = ch0_sample;
    smp[1] = ch1_sample;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    alm_detector #(
      .SW (SW),
      .LW (LW)
    ) i_det (
      .mode   (det_mode),
      .sample (smp[c]),
      .mag    (mag[c])
    );

    alm_averager #(
      .LW (LW),
      .CW (CW),
      .CF (CF)
    ) i_avg (
      .clk   (clk),
      .rst_n (rst_s_n),
      .en    (vld[c]),
      .det   (mag[c]),
      .coef  (coef),
      .level (lvl[c])
    );
  end

  always_comb begin
    if (rd_addr == LVL0_ADDR)      rd_data = lvl[0];
    else if (rd_addr == LVL1_ADDR) rd_data = lvl[1];
    else                           rd_data = '0;
  end
endmodule

// File: rtl/alm_checker.sv
module alm_checker #(
  parameter int                SW   = 24,
  parameter int                CW   = 26,
  parameter int                LW   = 32,
  parameter int                AW   = 8,
  parameter logic [AW-1:0]     A0   = 8'h6B,
  parameter logic [AW-1:0]     A1   = 8'h6C
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          det_mode,
  input logic [CW-1:0] coef,
  input logic          ch0_valid,
  input logic          ch1_valid,
  input logic [AW-1:0] rd_addr,
  input logic [LW-1:0] rd_data,
  input logic [LW-1:0] lvl0,
  input logic [LW-1:0] lvl1
);
  localparam logic [LW-1:0] ABS_MAX = LW'(1) << (SW - 1);

  p_zero_at_release_r1: assert property (@(posedge clk)
    $rose(rst_s_n) |-> (lvl0 == '0 && lvl1 == '0));

  p_hold_ch0_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ch0_valid |=> $stable(lvl0));

  p_hold_ch1_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ch1_valid |=> $stable(lvl1));

  p_abs_bound_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ch0_valid && !det_mode && coef == '0) |=> (lvl0 <= ABS_MAX));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_addr != A0 && rd_addr != A1) |-> (rd_data == '0));
endmodule

bind audio_level_meter alm_checker #(
  .SW (SW),
  .CW (CW),
  .LW (LW),
  .AW (AW),
  .A0 (LVL0_ADDR),
  .A1 (LVL1_ADDR)
) i_alm_checker (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .det_mode  (det_mode),
  .coef      (coef),
  .ch0_valid (ch0_valid),
  .ch1_valid (ch1_valid),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .lvl0      (lvl[0]),
  .lvl1      (lvl[1])
);

// File: tb/test_audio_level_meter.sv
module test_audio_level_meter;
  logic        clk;
  logic        rst_n;
  logic        det_mode;
  logic [25:0] coef;
  logic        ch0_valid;
  logic [23:0] ch0_sample;
  logic        ch1_valid;
  logic [23:0] ch1_sample;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;

  int total = 0;
  int bad   = 0;
  longint m0 = 0;
  longint m1 = 0;

  audio_level_meter i_audio_level_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .det_mode   (det_mode),
    .coef       (coef),
    .ch0_valid  (ch0_valid),
    .ch0_sample (ch0_sample),
    .ch1_valid  (ch1_valid),
    .ch1_sample (ch1_sample),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        mode;
    logic [25:0] c;
    logic        v0;
    logic [23:0] s0;
    logic        v1;
    logic [23:0] s1;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 26'h0000000, 1'b1, 24'hFFFF9C, 1'b1, 24'h0000C8, "R2 "},
    '{1'b0, 26'h0000000, 1'b1, 24'h800000, 1'b0, 24'h000000, "R2 "},
    '{1'b0, 26'h0400000, 1'b1, 24'h0003E8, 1'b1, 24'hFFFFFD, "R4 "},
    '{1'b0, 26'h0400000, 1'b1, 24'h0003E8, 1'b0, 24'h123456, "R6 "},
    '{1'b0, 26'h3C00000, 1'b1, 24'h000101, 1'b1, 24'hFFF000, "R8 "},
    '{1'b1, 26'h0000000, 1'b1, 24'h7FFFFF, 1'b1, 24'hFFFF4B, "R3 "},
    '{1'b1, 26'h0200000, 1'b1, 24'hFFF000, 1'b1, 24'h00B505, "R3 "},
    '{1'b1, 26'h0600000, 1'b0, 24'h000777, 1'b1, 24'h0186A0, "R10"},
    '{1'b0, 26'h0800000, 1'b1, 24'h000005, 1'b1, 24'h000005, "R4 "},
    '{1'b0, 26'h3FFFFFF, 1'b1, 24'h00ABCD, 1'b1, 24'hF54321, "R8 "},
    '{1'b1, 26'h0155555, 1'b1, 24'h800000, 1'b1, 24'h000001, "R4 "},
    '{1'b0, 26'h0000001, 1'b1, 24'h000003, 1'b1, 24'hFFFFFF, "R10"}
  };

  function automatic longint det_f(logic mode, logic [23:0] s);
    longint x;
    x = longint'($signed(s));
    if (mode) return (x * x) >>> 15;
    return (x < 0) ? -x : x;
  endfunction

  function automatic longint step_f(longint prev, longint d, logic [25:0] c);
    longint a;
    longint t;
    longint one;
    one = 1;
    a = longint'($signed(c));
    t = ((one <<< 23) - a) * d + a * prev + (one <<< 22);
    t = t >>> 23;
    if (t < 0) t = 0;
    if (t > 64'sh0FFFFFFFF) t = 64'sh0FFFFFFFF;
    return t;
  endfunction

  task automatic check(input logic [7:0] addr, input longint exp, input string tag);
    rd_addr = addr;
    #1;
    total++;
    if (rd_data !== exp[31:0]) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, rd_data, exp[31:0]);
    end
  endtask

  task automatic apply(input logic mode, input logic [25:0] c,
                       input logic v0, input logic [23:0] s0,
                       input logic v1, input logic [23:0] s1);
    @(negedge clk);
    det_mode = mode; coef = c;
    ch0_valid = v0; ch0_sample = s0;
    ch1_valid = v1; ch1_sample = s1;
    @(negedge clk);
    ch0_valid = 1'b0; ch1_valid = 1'b0;
    if (v0) m0 = step_f(m0, det_f(mode, s0), c);
    if (v1) m1 = step_f(m1, det_f(mode, s1), c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m0 = 0; m1 = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; det_mode = 1'b0; coef = '0;
    ch0_valid = 1'b0; ch0_sample = '0;
    ch1_valid = 1'b0; ch1_sample = '0;
    rd_addr = 8'h00;
    repeat (3) @(negedge clk);
    check(8'h6B, 0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(8'h6B, 0, "R1");
    check(8'h6C, 0, "R1");

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].mode, VEC[i].c, VEC[i].v0, VEC[i].s0, VEC[i].v1, VEC[i].s1);
      check(8'h6B, m0, string'(VEC[i].tag));
      check(8'h6C, m1, string'(VEC[i].tag));
    end

    // R2 hand value: most negative sample
    apply(1'b0, 26'h0, 1'b1, 24'h800000, 1'b0, 24'h0);
    check(8'h6B, 64'd8388608, "R2 min sample");

    // R5: valid low, samples toggling
    @(negedge clk);
    ch0_valid = 1'b0; ch1_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      ch0_sample = 24'h7FFFFF ^ 24'(k); ch1_sample = 24'h800000 + 24'(k);
      @(negedge clk);
    end
    check(8'h6B, m0, "R5");
    check(8'h6C, m1, "R5");

    // R9: unmapped addresses return zero while levels are nonzero
    check(8'h00, 0, "R9");
    check(8'h6A, 0, "R9");
    check(8'h6D, 0, "R9");
    check(8'hFF, 0, "R9");

    // R7 upper clamp: load near full scale, then grow by 1.5 per step
    apply(1'b0, 26'h0, 1'b1, 24'h7FFFFF, 1'b1, 24'h7FFFFF);
    for (int k = 0; k < 20; k++) begin
      apply(1'b0, 26'h0C00000, 1'b1, 24'h0, 1'b0, 24'h0);
      check(8'h6B, m0, "R7 growth");
    end
    check(8'h6B, 64'h0FFFFFFFF, "R7 top clamp");
    check(8'h6C, 64'd8388607, "R6 other channel");

    // R7 lower clamp with negative weight (R8)
    apply(1'b0, 26'h3800000, 1'b0, 24'h0, 1'b1, 24'h0);
    check(8'h6C, 0, "R7 bottom clamp");
    check(8'h6B, 64'h0FFFFFFFF, "R6 hold");

    // R1: reset in the middle of operation
    do_reset();
    check(8'h6B, 0, "R1 mid-run");
    check(8'h6C, 0, "R1 mid-run");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule